// File: doc/BRIEF.md
# Multiplexed LCD Scan Sequencer

The block time-multiplexes a passive LCD panel. A one-cycle refresh tick from an external oscillator advances a slot counter; each backplane owns four consecutive ticks, and a full refresh walks through the programmed number of backplanes, 2 to 8. For the backplane that is currently active, the matching row of a 24-bit-wide display memory is steered to all segment outputs. Every backplane and segment output is a 2-bit tap select that picks one of four levels on an external voltage ladder. The first two ticks of a slot use positive polarity and the last two use negative polarity, so no pixel sees a net DC voltage over a refresh.

Several chips can share one panel. The master drives the backplanes and a once-per-refresh sync line. A slave turns off its backplane-1 driver and uses that shared line as a resynchronisation input. Every chip drives its own segment lines. While the serial port reports a transfer in progress, the segments are forced to the off level. The scan continues during that time.

Top module: `lcd_scan_seq`

## Requirements
- R1: Each tick advances a 2-bit slot counter. After slot 3 the active backplane moves to the next one, and from the last programmed backplane it wraps to backplane 1. A refresh is therefore 4·h ticks long.
- R2: Backplane levels are 2-bit codes. In slots 0–1 (positive) the active backplane is 3 and the others are 1. In slots 2–3 (negative) the active backplane is 0 and the others are 2.
- R3: Segment s takes bit `row*24+s` of the memory input. A set bit gives on (0 positive, 3 negative) and a clear bit gives off (2 positive, 1 negative).
- R4: The 3-bit count code gives h = code+1. Code 0 is treated as code 1, so h = 2.
- R5: Backplane outputs with an index at or above h stay at the non-select level for the current polarity.
- R6: While busy is high, every segment shows the off level for the current polarity. The tick and backplane counters keep advancing.
- R7: bp1_oe_o equals the master flag, so a slave's backplane-1 driver is off.
- R8: A slave restarts at slot 0 of backplane 1 on the clock after a rising edge of sync_i. This restart takes priority over a coincident tick. A held-high sync_i does not restart it again. A master ignores sync_i.
- R9: sync_o is high exactly while a master is on backplane 1, and it is always low on a slave.
- R10: After reset the block is at slot 0 of backplane 1.
- R11: Without a tick or a resync, the backplane outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle refresh oscillator tick |
| bp_code_i | input | 3 | Backplane count code (h−1) |
| master_i | input | 1 | 1 = master, 0 = slave |
| busy_i | input | 1 | Serial transfer in progress |
| sync_i | input | 1 | Shared backplane-1 sync line, as seen by a slave |
| ram_i | input | 192 | Display memory, row r segment s at bit r*24+s |
| bp_lvl_o | output | 16 | Backplane tap codes, 2 bits per backplane |
| seg_lvl_o | output | 48 | Segment tap codes, 2 bits per segment |
| bp1_oe_o | output | 1 | Backplane-1 driver enable |
| sync_o | output | 1 | Refresh sync, high during backplane 1 on a master |

## Verification
The assertions assume that ticks are single-cycle strobes with at least one idle clock between them. They also assume that a slave's sync edge arrives as a clean level change sampled on the clock. The bench drives the tick for exactly one clock and then leaves one idle clock. It changes the count code, the master flag and busy only between ticks. It raises sync_i once per test, and in one case on the same clock as a tick, to exercise the priority rule.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef logic [1:0] lvl_t;

  // pol 0: positive half, pol 1: negative half
  function automatic lvl_t bp_level(input logic sel, input logic pol);
    if (!pol) return sel ? 2'd3 : 2'd1;
    else      return sel ? 2'd0 : 2'd2;
  endfunction

  function automatic lvl_t seg_level(input logic on, input logic pol);
    if (!pol) return on ? 2'd0 : 2'd2;
    else      return on ? 2'd3 : 2'd1;
  endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int ROW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ROW_W-1:0] last_i,
  input  logic             master_i,
  input  logic             sync_i,
  output logic [1:0]       slot_o,
  output logic [ROW_W-1:0] row_o
);
  logic [1:0]       slot_q;
  logic [ROW_W-1:0] row_q;
  logic             sync_q;
  logic             resync;

  assign resync = !master_i && sync_i && !sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 2'd0;
      row_q  <= {ROW_W{1'b0}};
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (resync) begin
        slot_q <= 2'd0;
        row_q  <= {ROW_W{1'b0}};
      end else if (tick_i) begin
        slot_q <= slot_q + 2'd1;
        if (slot_q == 2'd3)
          row_q <= (row_q >= last_i) ? {ROW_W{1'b0}} : row_q + 1'b1;
      end
    end
  end

  assign slot_o = slot_q;
  assign row_o  = row_q;
endmodule

// File: rtl/lcd_bp_drive.sv
module lcd_bp_drive
  import lcd_scan_pkg::*;
#(
  parameter int N_BP  = 8,
  parameter int ROW_W = 3
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic [ROW_W-1:0]  last_i,
  input  logic              pol_i,
  output logic [2*N_BP-1:0] lvl_o
);
  for (genvar i = 0; i < N_BP; i++) begin : g_bp
    logic sel;
    assign sel = (row_i == ROW_W'(i)) && (ROW_W'(i) <= last_i);
    assign lvl_o[2*i +: 2] = bp_level(sel, pol_i);
  end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_scan_pkg::*;
#(
  parameter int N_BP  = 8,
  parameter int N_SEG = 24,
  parameter int ROW_W = 3
) (
  input  logic [N_BP*N_SEG-1:0] ram_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic                  pol_i,
  input  logic                  busy_i,
  output logic [2*N_SEG-1:0]    lvl_o
);
  logic [N_SEG-1:0] row_bits;

  always_comb begin
    row_bits = '0;
    for (int r = 0; r < N_BP; r++)
      if (row_i == ROW_W'(r)) row_bits = ram_i[r*N_SEG +: N_SEG];
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    assign lvl_o[2*s +: 2] = seg_level(row_bits[s] && !busy_i, pol_i);
  end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
  parameter int N_BP  = 8,
  parameter int N_SEG = 24,
  localparam int ROW_W = $clog2(N_BP)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [ROW_W-1:0]      bp_code_i,
  input  logic                  master_i,
  input  logic                  busy_i,
  input  logic                  sync_i,
  input  logic [N_BP*N_SEG-1:0] ram_i,
  output logic [2*N_BP-1:0]     bp_lvl_o,
  output logic [2*N_SEG-1:0]    seg_lvl_o,
  output logic                  bp1_oe_o,
  output logic                  sync_o
);
  logic [ROW_W-1:0] last_idx;
  logic [1:0]       slot;
  logic [ROW_W-1:0] row;
  logic             pol;

  // code 0 would mean a single backplane: clamp to two
  assign last_idx = (bp_code_i == '0) ? ROW_W'(1) : bp_code_i;
  assign pol      = slot[1];

  lcd_scan_timer #(.ROW_W(ROW_W)) i_timer (
    .clk_i, .rst_ni, .tick_i,
    .last_i(last_idx), .master_i, .sync_i,
    .slot_o(slot), .row_o(row)
  );

  lcd_bp_drive #(.N_BP(N_BP), .ROW_W(ROW_W)) i_bp (
    .row_i(row), .last_i(last_idx), .pol_i(pol), .lvl_o(bp_lvl_o)
  );

  lcd_seg_drive #(.N_BP(N_BP), .N_SEG(N_SEG), .ROW_W(ROW_W)) i_seg (
    .ram_i, .row_i(row), .pol_i(pol), .busy_i, .lvl_o(seg_lvl_o)
  );

  assign bp1_oe_o = master_i;
  assign sync_o   = master_i && (row == '0);
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
  parameter int N_BP  = 8,
  parameter int N_SEG = 24,
  localparam int ROW_W = $clog2(N_BP)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [ROW_W-1:0]      bp_code_i,
  input logic                  master_i,
  input logic                  busy_i,
  input logic                  sync_i,
  input logic [N_BP*N_SEG-1:0] ram_i,
  input logic [2*N_BP-1:0]     bp_lvl_o,
  input logic [2*N_SEG-1:0]    seg_lvl_o,
  input logic                  bp1_oe_o,
  input logic                  sync_o
);
  logic [N_BP-1:0]  sel_vec;
  logic [N_SEG-1:0] on_vec;
  logic [N_SEG-1:0] sel_row;
  logic             above_sel;
  int               last_c;

  // extreme ladder taps (0 or 3) mark select / on in either polarity
  always_comb begin
    last_c    = (bp_code_i == '0) ? 1 : int'(bp_code_i);
    above_sel = 1'b0;
    sel_row   = '0;
    for (int i = 0; i < N_BP; i++) begin
      sel_vec[i] = (bp_lvl_o[2*i +: 2] == 2'd0) || (bp_lvl_o[2*i +: 2] == 2'd3);
      if (i > last_c && sel_vec[i]) above_sel = 1'b1;
      if (sel_vec[i]) sel_row = ram_i[i*N_SEG +: N_SEG];
    end
    for (int s = 0; s < N_SEG; s++)
      on_vec[s] = (seg_lvl_o[2*s +: 2] == 2'd0) || (seg_lvl_o[2*s +: 2] == 2'd3);
  end

  p_one_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_vec) <= 1);

  p_seg_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $countones(sel_vec) == 1) |-> (on_vec == sel_row));

  p_unused_nonsel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !above_sel);

  p_busy_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (on_vec == '0));

  p_slave_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !bp1_oe_o);

  p_slave_nosync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !sync_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && master_i) |=>
      (bp_lvl_o == $past(bp_lvl_o)) || (bp_code_i != $past(bp_code_i)));
endmodule

bind lcd_scan_seq lcd_scan_chk #(.N_BP(N_BP), .N_SEG(N_SEG)) i_chk (.*);

// File: tb/test_lcd_scan_seq.sv
`timescale 1ns/1ps
module test_lcd_scan_seq;
  localparam int N_BP = 8;
  localparam int N_SEG = 24;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  tick_i = 1'b0;
  logic [2:0]            bp_code_i = 3'd7;
  logic                  master_i = 1'b1;
  logic                  busy_i = 1'b0;
  logic                  sync_i = 1'b0;
  logic [N_BP*N_SEG-1:0] ram_i = '0;
  logic [2*N_BP-1:0]     bp_lvl_o;
  logic [2*N_SEG-1:0]    seg_lvl_o;
  logic                  bp1_oe_o;
  logic                  sync_o;

  int checks = 0;
  int fails  = 0;
  int mslot  = 0;
  int mrow   = 0;

  always #5 clk = ~clk;

  lcd_scan_seq #(.N_BP(N_BP), .N_SEG(N_SEG)) i_lcd_scan_seq (
    .clk_i(clk), .rst_ni, .tick_i, .bp_code_i, .master_i, .busy_i,
    .sync_i, .ram_i, .bp_lvl_o, .seg_lvl_o, .bp1_oe_o, .sync_o
  );

  function automatic logic [1:0] e_bp(input bit sel, input bit pol);
    if (!pol) return sel ? 2'd3 : 2'd1;
    return sel ? 2'd0 : 2'd2;
  endfunction

  function automatic logic [1:0] e_seg(input bit on, input bit pol);
    if (!pol) return on ? 2'd0 : 2'd2;
    return on ? 2'd3 : 2'd1;
  endfunction

  function automatic int last_of(input logic [2:0] code);
    return (code == 3'd0) ? 1 : int'(code);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [2*N_BP-1:0]  xb;
    logic [2*N_SEG-1:0] xs;
    bit pol;
    pol = (mslot >= 2);
    for (int i = 0; i < N_BP; i++)
      xb[2*i +: 2] = e_bp((i == mrow) && (i <= last_of(bp_code_i)), pol);
    for (int s = 0; s < N_SEG; s++)
      xs[2*s +: 2] = e_seg(ram_i[mrow*N_SEG + s] && !busy_i, pol);
    chk({tag, " bp"},  64'(bp_lvl_o), 64'(xb));
    chk({tag, " seg"}, 64'(seg_lvl_o), 64'(xs));
    chk({tag, " R7 oe"}, 64'(bp1_oe_o), 64'(master_i));
    chk({tag, " R9 sync"}, 64'(sync_o), 64'(master_i && mrow == 0));
  endtask

  task automatic fill_ram(input int seed);
    for (int k = 0; k < N_BP*N_SEG; k++)
      ram_i[k] = (((k * 7 + seed) % 5) < 2);
  endtask

  task automatic do_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    mslot = mslot + 1;
    if (mslot == 4) begin
      mslot = 0;
      mrow = (mrow >= last_of(bp_code_i)) ? 0 : mrow + 1;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    fill_ram(3);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    mslot = 0; mrow = 0;
    @(negedge clk);
    check_all("R10 reset");
  endtask

  // R1 R2 R3 R5 R9: full refresh plus one slot
  task automatic t_scan(input logic [2:0] code, input int seed);
    int h;
    fill_ram(seed);
    @(negedge clk) bp_code_i = code;
    h = last_of(code) + 1;
    for (int n = 0; n < 4*h + 4; n++) begin
      do_tick();
      check_all("R1 R2 R3 R5 scan");
    end
  endtask

  // R4: code 0 acts as h = 2, so 8 ticks return to backplane 1 slot 0
  task automatic t_code0();
    @(negedge clk) bp_code_i = 3'd0;
    while (mslot != 0 || mrow != 0) do_tick();
    for (int n = 0; n < 8; n++) do_tick();
    check_all("R4 code0");
    chk("R4 wrap bp1 select", 64'(bp_lvl_o[1:0]), 64'(2'd3));
    chk("R4 bp3 nonselect", 64'(bp_lvl_o[5:4]), 64'(2'd1));
  endtask

  // R6: busy blanks segments, counters keep running
  task automatic t_busy();
    fill_ram(1);
    @(negedge clk) bp_code_i = 3'd3; busy_i = 1'b1;
    @(negedge clk);
    check_all("R6 busy");
    for (int n = 0; n < 6; n++) begin
      do_tick();
      check_all("R6 busy run");
    end
    @(negedge clk) busy_i = 1'b0;
    @(negedge clk);
    check_all("R6 after busy");
  endtask

  // R11: no tick, outputs stay put
  task automatic t_hold();
    logic [2*N_BP-1:0] snap;
    snap = bp_lvl_o;
    repeat (10) @(negedge clk);
    chk("R11 hold", 64'(bp_lvl_o), 64'(snap));
    check_all("R11 hold model");
  endtask

  // R7 R8 R9: slave behaviour and resync
  task automatic t_slave();
    @(negedge clk) master_i = 1'b0; bp_code_i = 3'd7;
    @(negedge clk);
    check_all("R7 slave");
    do_tick(); do_tick(); do_tick(); do_tick(); do_tick();
    check_all("R8 slave run");
    @(negedge clk) sync_i = 1'b1;
    @(negedge clk);
    mslot = 0; mrow = 0;
    check_all("R8 resync");
    do_tick(); do_tick();
    check_all("R8 held sync no restart");
    @(negedge clk) sync_i = 1'b0;
    do_tick(); do_tick(); do_tick();
    @(negedge clk) sync_i = 1'b1; tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    mslot = 0; mrow = 0;
    check_all("R8 sync beats tick");
    @(negedge clk) sync_i = 1'b0;
    // master ignores sync
    @(negedge clk) master_i = 1'b1;
    do_tick(); do_tick(); do_tick(); do_tick(); do_tick();
    @(negedge clk) sync_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_all("R8 master ignores sync");
    sync_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_scan(3'd7, 2);
    t_scan(3'd2, 4);
    t_scan(3'd1, 0);
    t_code0();
    t_busy();
    t_hold();
    t_slave();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule